// File: doc/BRIEF.md
# Serial divide-by-three unit

This block divides an unsigned binary operand by three while the operand streams in serially, most significant bit first, one bit per qualified clock. For every accepted bit it keeps the running remainder modulo three and emits one quotient bit. Concatenating the quotient bits in arrival order gives the operand divided by three. After the last bit of an operand the remainder output holds the operand modulo three.

A start strobe marks the first bit of a new operand. It clears the remainder, the quotient bit and the bit count. When start and valid come together, the bit on that cycle is taken as the first bit of the fresh operand. After a fixed, parameterised number of bits (three by default), a one-cycle done pulse signals that the operand is complete. A second parameter selects how the remainder is stored: as a two-flop binary code or as a three-flop one-hot code. Both choices present the same ports and the same timing.

Top module: `div3_serial`

## Requirements
- R1: On a cycle with `bit_vld_i` high, the remainder moves to (2*r + x) mod 3, where r is the old remainder and x is `bit_i`. In full: from 0 it goes to 0 (x=0) or 1 (x=1); from 1 to 2 or 0; from 2 to 1 or 2. The new value is visible on `rem_o` (0, 1 or 2 in binary) after that clock edge.
- R2: On the same edge, `quo_o` takes the quotient bit of the accepted input. The bit is 1 exactly when 2*r + x is 3 or more.
- R3: When `bit_vld_i` and `start_i` are both low, `rem_o` and `quo_o` hold their values whatever `bit_i` does. No bit is counted.
- R4: While `rst_i` (synchronous, active high) is asserted, the block returns to remainder 0, `quo_o` = 0, `done_o` = 0 and a bit count of zero.
- R5: `start_i` clears the remainder, the quotient bit and the bit count. With `bit_vld_i` low, this leaves `rem_o` = 0 and `quo_o` = 0. With `bit_vld_i` high, the bit on that cycle is processed from remainder 0 as bit 1 of a new operand.
- R6: `done_o` is high for exactly the one cycle that follows the edge accepting the OP_BITS-th bit of an operand. At that time, `rem_o` equals the operand mod 3, and the OP_BITS quotient bits taken so far, MSB first, equal the operand divided by 3.
- R7: With ONE_HOT = 0 the remainder is held as 00/01/10. With ONE_HOT = 1 it is held as 001/010/100. Port behaviour is identical in both settings.
- R8: `rem_o` never shows the value 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new operand: clears remainder, quotient bit and count |
| bit_vld_i | input | 1 | Qualifies `bit_i` for this cycle |
| bit_i | input | 1 | Serial operand bit, most significant first |
| quo_o | output | 1 | Quotient bit of the latest accepted input bit |
| rem_o | output | 2 | Current remainder, 0..2 |
| done_o | output | 1 | One-cycle pulse after the last bit of an operand |

## Verification
The bench builds two copies side by side, both with OP_BITS = 3: one with ONE_HOT = 0 and one with ONE_HOT = 1. Both see identical stimulus. The three-bit width makes all eight operands reachable, so every remainder transition and quotient bit is covered exhaustively, and the two encodings are held to the same expected values on every check. Directed sequences add idle gaps, a restart in the middle of an operand (with and without a coincident bit) and a reset in the middle of an operand.

// File: rtl/div3_pkg.sv
package div3_pkg;

    typedef logic [1:0] rem_t;

    localparam rem_t REM0 = 2'd0;
    localparam rem_t REM1 = 2'd1;
    localparam rem_t REM2 = 2'd2;

    typedef struct packed {
        logic quo;
        rem_t rem;
    } step_t;

    typedef struct packed {
        logic legal;
        rem_t rem;
    } dec_t;

    // One serial division step: value = 2*r + x, which is {r, x}.
    function automatic step_t div3_step(input rem_t r, input logic x);
        logic [2:0] v;
        step_t      s;
        v = {r, x};
        if (v >= 3'd3) begin
            s.quo = 1'b1;
            s.rem = rem_t'(v - 3'd3);
        end else begin
            s.quo = 1'b0;
            s.rem = rem_t'(v);
        end
        return s;
    endfunction

    function automatic logic [2:0] enc_onehot(input rem_t r);
        case (r)
            REM1:    return 3'b010;
            REM2:    return 3'b100;
            default: return 3'b001;
        endcase
    endfunction

    function automatic dec_t dec_onehot(input logic [2:0] s);
        dec_t d;
        case (s)
            3'b001:  d = '{legal: 1'b1, rem: REM0};
            3'b010:  d = '{legal: 1'b1, rem: REM1};
            3'b100:  d = '{legal: 1'b1, rem: REM2};
            default: d = '{legal: 1'b0, rem: REM0};
        endcase
        return d;
    endfunction

    function automatic dec_t dec_binary(input logic [1:0] s);
        dec_t d;
        if (s == 2'b11) d = '{legal: 1'b0, rem: REM0};
        else            d = '{legal: 1'b1, rem: rem_t'(s)};
        return d;
    endfunction

endpackage

// File: rtl/div3_step_logic.sv
module div3_step_logic
    import div3_pkg::*;
(
    input  dec_t  cur_i,
    input  logic  start_i,
    input  logic  bit_i,
    output step_t nxt_o
);
    rem_t base;

    always_comb begin
        base = start_i ? REM0 : cur_i.rem;
        if (!start_i && !cur_i.legal) begin
            // corrupted state: fall back to remainder 0, drop the bit
            nxt_o = '{quo: 1'b0, rem: REM0};
        end else begin
            nxt_o = div3_step(base, bit_i);
        end
    end
endmodule

// File: rtl/div3_state_reg.sv
module div3_state_reg
    import div3_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic load_i,
    input  logic clr_i,
    input  rem_t nxt_rem_i,
    output dec_t cur_o
);
    localparam int SW = ONE_HOT ? 3 : 2;

    logic [SW-1:0] state_q;
    logic [SW-1:0] enc_nxt;
    logic [SW-1:0] enc_zero;

    generate
        if (ONE_HOT) begin : g_onehot
            assign enc_nxt  = enc_onehot(nxt_rem_i);
            assign enc_zero = enc_onehot(REM0);
            assign cur_o    = dec_onehot(state_q);
        end else begin : g_binary
            assign enc_nxt  = nxt_rem_i;
            assign enc_zero = REM0;
            assign cur_o    = dec_binary(state_q);
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i)       state_q <= enc_zero;
        else if (load_i) state_q <= enc_nxt;
        else if (clr_i)  state_q <= enc_zero;
    end

    // R7: every accepted bit leaves a legal code behind
    p_legal_after_load_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> cur_o.legal);
endmodule

// File: rtl/div3_bit_counter.sv
module div3_bit_counter #(
    parameter int OP_BITS = 3
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    input  logic vld_i,
    output logic done_o
);
    localparam int CW = $clog2(OP_BITS) + 1;
    localparam logic [CW-1:0] LAST = CW'(OP_BITS - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] base;
    logic          done_q;

    assign base   = start_i ? '0 : cnt_q;
    assign done_o = done_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (vld_i) begin
            if (base == LAST) begin
                cnt_q  <= '0;
                done_q <= 1'b1;
            end else begin
                cnt_q  <= base + 1'b1;
                done_q <= 1'b0;
            end
        end else begin
            if (start_i) cnt_q <= '0;
            done_q <= 1'b0;
        end
    end

    generate
        if (OP_BITS > 1) begin : g_pulse_chk
            // R6: an operand of several bits cannot finish twice in a row
            p_done_single_r6: assert property (@(posedge clk_i) disable iff (rst_i)
                done_q |=> !done_q);
        end
    endgenerate

    // R6: completion only ever follows an accepted bit
    p_done_after_bit_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !vld_i |=> !done_q);
endmodule

// File: rtl/div3_serial.sv
module div3_serial
    import div3_pkg::*;
#(
    parameter int OP_BITS = 3,
    parameter bit ONE_HOT = 1'b0
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       start_i,
    input  logic       bit_vld_i,
    input  logic       bit_i,
    output logic       quo_o,
    output logic [1:0] rem_o,
    output logic       done_o
);
    dec_t  cur;
    step_t nxt;
    logic  quo_q;

    div3_state_reg #(.ONE_HOT(ONE_HOT)) u_state (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .load_i    (bit_vld_i),
        .clr_i     (start_i),
        .nxt_rem_i (nxt.rem),
        .cur_o     (cur)
    );

    div3_step_logic u_step (
        .cur_i   (cur),
        .start_i (start_i),
        .bit_i   (bit_i),
        .nxt_o   (nxt)
    );

    div3_bit_counter #(.OP_BITS(OP_BITS)) u_cnt (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start_i),
        .vld_i   (bit_vld_i),
        .done_o  (done_o)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i)          quo_q <= 1'b0;
        else if (bit_vld_i) quo_q <= nxt.quo;
        else if (start_i)   quo_q <= 1'b0;
    end

    assign quo_o = quo_q;
    assign rem_o = cur.rem;

    // R3: idle cycles change nothing
    p_hold_idle_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!bit_vld_i && !start_i) |=> ($stable(rem_o) && $stable(quo_o)));

    // R5: a bare start lands in remainder 0 with a cleared quotient bit
    p_start_clears_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && !bit_vld_i) |=> (rem_o == 2'd0 && !quo_o));

    // R1: remainder 1 with input 1 wraps to 0
    p_step_wrap_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (bit_vld_i && !start_i && rem_o == 2'd1 && bit_i) |=> (rem_o == 2'd0));

    // R2: remainder 2 with input 0 gives quotient 1, remainder 1
    p_quo_set_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (bit_vld_i && !start_i && rem_o == 2'd2 && !bit_i) |=> (quo_o && rem_o == 2'd1));

    // R8: the unused code is never presented
    p_rem_range_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        rem_o != 2'd3);
endmodule

// File: tb/tb_div3_serial.sv
module tb_div3_serial;

    typedef struct packed {
        logic [2:0] op;
        logic [2:0] quo;
        logic [1:0] rem;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{op: 3'd0, quo: 3'd0, rem: 2'd0},
        '{op: 3'd1, quo: 3'd0, rem: 2'd1},
        '{op: 3'd2, quo: 3'd0, rem: 2'd2},
        '{op: 3'd3, quo: 3'd1, rem: 2'd0},
        '{op: 3'd4, quo: 3'd1, rem: 2'd1},
        '{op: 3'd5, quo: 3'd1, rem: 2'd2},
        '{op: 3'd6, quo: 3'd2, rem: 2'd0},
        '{op: 3'd7, quo: 3'd2, rem: 2'd1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic vld = 1'b0;
    logic bit_in = 1'b0;
    logic       quo_b, quo_h, done_b, done_h;
    logic [1:0] rem_b, rem_h;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    div3_serial #(.OP_BITS(3), .ONE_HOT(1'b0)) dut (
        .clk_i(clk), .rst_i(rst), .start_i(start), .bit_vld_i(vld), .bit_i(bit_in),
        .quo_o(quo_b), .rem_o(rem_b), .done_o(done_b)
    );

    div3_serial #(.OP_BITS(3), .ONE_HOT(1'b1)) dut_oh (
        .clk_i(clk), .rst_i(rst), .start_i(start), .bit_vld_i(vld), .bit_i(bit_in),
        .quo_o(quo_h), .rem_o(rem_h), .done_o(done_h)
    );

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    // both encodings must agree with the expected values
    task automatic check_both(input string req, input int r, input int q, input int d);
        check({req, " rem bin"}, rem_b, r);
        check({req, " rem 1hot"}, rem_h, r);
        check({req, " quo bin"}, quo_b, q);
        check({req, " quo 1hot"}, quo_h, q);
        check({req, " done bin"}, done_b, d);
        check({req, " done 1hot"}, done_h, d);
    endtask

    // drive at a falling edge, let one rising edge pass, return at the next falling edge
    task automatic cycle(input logic s, input logic v, input logic b);
        start  = s;
        vld    = v;
        bit_in = b;
        @(posedge clk);
        @(negedge clk);
    endtask

    int m_r;
    int m_q;
    int t_r;

    // expected step from the requirement text
    task automatic model(input logic b);
        t_r = 2 * m_r + int'(b);
        m_q = (t_r >= 3) ? 1 : 0;
        m_r = t_r % 3;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        int qs;
        @(negedge clk);
        cycle(1'b0, 1'b0, 1'b0);
        cycle(1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        // R4: state straight after reset
        check_both("R4 reset", 0, 0, 0);

        // exhaustive walk of the operand table
        foreach (VEC[k]) begin
            m_r = 0;
            qs  = 0;
            for (int b = 2; b >= 0; b--) begin
                if (k % 2 == 1 && b == 1) begin
                    // R3: an idle cycle with bit_i toggled leaves everything held
                    cycle(1'b0, 1'b0, ~VEC[k].op[b]);
                    check_both("R3 idle gap", m_r, m_q, 0);
                end
                cycle(b == 2, 1'b1, VEC[k].op[b]);
                if (b == 2) m_r = 0;
                model(VEC[k].op[b]);
                qs = qs * 2 + int'(quo_b);
                // R1 R2: per-bit remainder and quotient, done only after the last bit (R6)
                check_both("R1 R2 step", m_r, m_q, (b == 0) ? 1 : 0);
                check("R8 range", (rem_b == 2'd3 || rem_h == 2'd3) ? 1 : 0, 0);
            end
            // R6: quotient stream and final remainder match the table, R7 both encodings
            check("R6 quotient stream", qs, int'(VEC[k].quo));
            check("R6 final rem", rem_b, int'(VEC[k].rem));
            check("R7 encodings agree", rem_h, int'(VEC[k].rem));
            cycle(1'b0, 1'b0, 1'b0);
            check("R6 done is one cycle", done_b + done_h, 0);
        end

        // R5: bare start in the middle of an operand
        cycle(1'b1, 1'b1, 1'b1);   // r=1
        cycle(1'b0, 1'b1, 1'b0);   // r=2, q=0
        check_both("R5 pre-start", 2, 0, 0);
        cycle(1'b1, 1'b0, 1'b1);
        check_both("R5 bare start", 0, 0, 0);
        cycle(1'b0, 1'b1, 1'b1);   // 6 = 110 -> r=1
        cycle(1'b0, 1'b1, 1'b1);   // r=0, q=1
        check_both("R6 no early done", 0, 1, 0);
        cycle(1'b0, 1'b1, 1'b0);
        check_both("R6 done after restart", 0, 0, 1);

        // R5: start together with a bit begins a fresh operand (4 = 100)
        cycle(1'b1, 1'b1, 1'b1);   // r=1
        cycle(1'b0, 1'b1, 1'b1);   // r=0, q=1
        cycle(1'b1, 1'b1, 1'b1);   // restart: r=1, q=0
        check_both("R5 start with bit", 1, 0, 0);
        cycle(1'b0, 1'b1, 1'b0);   // r=2
        check_both("R5 second bit", 2, 0, 0);
        cycle(1'b0, 1'b1, 1'b0);   // r=1, q=1
        check_both("R5 R6 restarted operand", 1, 1, 1);

        // R3: several idle cycles
        for (int i = 0; i < 4; i++) begin
            cycle(1'b0, 1'b0, i[0]);
            check_both("R3 long idle", 1, 1, 0);
        end

        // R4: reset in the middle of an operand
        cycle(1'b1, 1'b1, 1'b1);
        cycle(1'b0, 1'b1, 1'b0);
        rst = 1'b1;
        cycle(1'b0, 1'b1, 1'b1);
        rst = 1'b0;
        check_both("R4 mid reset", 0, 0, 0);
        // count restarted by reset: three fresh bits 011 -> q 001, r 0
        cycle(1'b0, 1'b1, 1'b0);
        cycle(1'b0, 1'b1, 1'b1);
        check_both("R4 count cleared", 1, 0, 0);
        cycle(1'b0, 1'b1, 1'b1);
        check_both("R4 R6 after reset", 0, 1, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule